// File: doc/BRIEF.md
# Host Access Wait-State Generator

This block stretches host bus cycles aimed at an arithmetic coprocessor. It holds an active-low pause line for as long as a pending access cannot safely finish. Bus decode happens upstream and presents one strobe-qualified access with a kind code: command write, operand push (data write) or operand pop (data read). The execution engine supplies a busy flag, and the read path supplies a flag showing that the output latch is occupied.

Every access first passes through a minimum-assertion delay. This is a shift register that is held clear while no strobe is present and fills with ones once a strobe appears. After the delay, writes wait only for the engine to go idle. A read also has to wait for a free output latch and for a fixed number of cycles in which the top-of-stack byte is moved into that latch. On the cycle the pause line releases, the block emits one strobe toward the command logic or the stack logic. The host must keep its control lines stable until the pause line is high again.

Top module: `wait_pause_gen`

## Requirements
- R1: While `rst_n` is low, `pause_n` is 1 and all three fire outputs are 0, whatever the other inputs are.
- R2: While `acc_valid` is 0, `pause_n` is 1 and no fire output is asserted.
- R3: For a write (kind 2'd0 command, 2'd1 operand push) with the engine idle, `pause_n` is low for exactly DLY_STAGES cycles counted from the first cycle of the strobe. It goes high in the next cycle.
- R4: A command write (kind 2'd0) attempted while `eng_busy` is 1 keeps `pause_n` low until `eng_busy` falls. `fire_cmd` pulses in the first cycle that has the engine idle and the minimum delay elapsed.
- R5: An operand push (kind 2'd1) attempted while busy is held in the same way, and it completes with `fire_push`.
- R6: An operand pop (kind 2'd2) with the engine idle and the latch free holds `pause_n` low for DLY_STAGES + XFER_CYCLES cycles. `xfer_active` is high during the last XFER_CYCLES of them, and `fire_pop` pulses when pause releases.
- R7: While `latch_full` is 1, a pop is held and its transfer count is frozen. Pause releases XFER_CYCLES cycles after the latch becomes free.
- R8: Each strobe produces exactly one fire pulse. While the strobe stays asserted after that pulse, `pause_n` stays high and nothing fires again.
- R9: The fire outputs are one-hot or all zero, and any fire coincides with `pause_n` high.
- R10: A pop attempted while busy waits for `eng_busy` to fall. It then needs XFER_CYCLES more cycles before it releases.
- R11: Dropping the strobe for even one cycle clears the delay register. The next strobe is held for the full DLY_STAGES cycles again.
- R12: Kind code 2'd3 is not an access: `pause_n` stays high and nothing fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host strobe active with chip selected |
| acc_kind | input | 2 | 0 command write, 1 operand push, 2 operand pop, 3 none |
| eng_busy | input | 1 | Execution engine is running a command |
| latch_full | input | 1 | Output latch still holds an unread byte |
| pause_n | output | 1 | Active-low wait request to the host |
| xfer_active | output | 1 | Top byte being moved into the output latch |
| fire_cmd | output | 1 | One-cycle command accept strobe |
| fire_push | output | 1 | One-cycle operand push strobe |
| fire_pop | output | 1 | One-cycle operand pop strobe |

## Verification
`pause_n`, `xfer_active` and the fire outputs are combinational from the registered delay, the transfer count and the completion flag. A result therefore shows up in the same cycle as the input change that enables it. The release of a write is due DLY_STAGES cycles after the strobe first appears, or in the cycle busy falls if that is later. A pop releases XFER_CYCLES cycles after the last of the delay, busy and latch conditions clears. The bench drives inputs on the falling edge and samples one time unit later. It counts low cycles from the first strobed cycle and compares that count, the transfer cycles and the fire kind with values derived from these rules.

// File: rtl/wp_pkg.sv
package wp_pkg;
   typedef enum logic [1:0] {
      ACC_CMD_WR  = 2'd0,
      ACC_PUSH    = 2'd1,
      ACC_POP     = 2'd2,
      ACC_NONE    = 2'd3
   } acc_kind_e;

   localparam int unsigned MAX_DLY_STAGES = 32;
endpackage

// File: rtl/wp_delay_line.sv
module wp_delay_line #(
   parameter int unsigned STAGES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic dly_done
);
   generate
      if (STAGES == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage_q <= 1'b0;
            else if (!run)   stage_q <= 1'b0;
            else             stage_q <= 1'b1;
         end
         assign dly_done = stage_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain_q <= '0;
            else if (!run)   chain_q <= '0;
            else             chain_q <= {chain_q[STAGES-2:0], 1'b1};
         end
         assign dly_done = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/wp_xfer_timer.sv
module wp_xfer_timer #(
   parameter int unsigned CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic active,
   output logic finished
);
   localparam int unsigned CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

   logic [CW-1:0] cnt_q;

   assign finished = (cnt_q == LIMIT);
   assign active   = adv && !finished;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (active)  cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/wp_hold_ctrl.sv
module wp_hold_ctrl
   import wp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  acc_kind_e  kind,
   input  logic       dly_done,
   input  logic       eng_busy,
   input  logic       latch_full,
   input  logic       xfer_finished,
   output logic       xfer_adv,
   output logic       pause_n,
   output logic [2:0] fire_vec
);
   logic served_q;
   logic is_pop;
   logic path_ok;
   logic fire;

   assign is_pop   = (kind == ACC_POP);
   assign xfer_adv = req && !served_q && dly_done && is_pop && !eng_busy && !latch_full;
   assign path_ok  = is_pop ? (xfer_finished && !latch_full) : 1'b1;
   assign fire     = req && !served_q && dly_done && !eng_busy && path_ok;
   assign pause_n  = !rst_n || !(req && !served_q && !fire);

   always_comb begin
      fire_vec = 3'b000;
      if (fire) begin
         unique case (kind)
            ACC_CMD_WR: fire_vec = 3'b001;
            ACC_PUSH:   fire_vec = 3'b010;
            ACC_POP:    fire_vec = 3'b100;
            default:    fire_vec = 3'b000;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      served_q <= 1'b0;
      else if (!req)   served_q <= 1'b0;
      else if (fire)   served_q <= 1'b1;
   end
endmodule

// File: rtl/wait_pause_gen.sv
module wait_pause_gen #(
   parameter int unsigned DLY_STAGES  = 4,
   parameter int unsigned XFER_CYCLES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc_valid,
   input  logic [1:0] acc_kind,
   input  logic       eng_busy,
   input  logic       latch_full,
   output logic       pause_n,
   output logic       xfer_active,
   output logic       fire_cmd,
   output logic       fire_push,
   output logic       fire_pop
);
   import wp_pkg::*;

   generate
      if (DLY_STAGES < 1 || DLY_STAGES > MAX_DLY_STAGES) begin : g_bad_dly
         $error("DLY_STAGES out of range");
      end
      if (XFER_CYCLES < 1) begin : g_bad_xfer
         $error("XFER_CYCLES must be at least 1");
      end
   endgenerate

   acc_kind_e  kind;
   logic       req;
   logic       dly_done;
   logic       xfer_adv;
   logic       xfer_finished;
   logic [2:0] fire_vec;

   assign kind = acc_kind_e'(acc_kind);
   assign req  = acc_valid && (kind != ACC_NONE);

   wp_delay_line #(.STAGES(DLY_STAGES)) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (req),
      .dly_done (dly_done)
   );

   wp_xfer_timer #(.CYCLES(XFER_CYCLES)) u_xfer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!req),
      .adv      (xfer_adv),
      .active   (xfer_active),
      .finished (xfer_finished)
   );

   wp_hold_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req           (req),
      .kind          (kind),
      .dly_done      (dly_done),
      .eng_busy      (eng_busy),
      .latch_full    (latch_full),
      .xfer_finished (xfer_finished),
      .xfer_adv      (xfer_adv),
      .pause_n       (pause_n),
      .fire_vec      (fire_vec)
   );

   assign fire_cmd  = fire_vec[0];
   assign fire_push = fire_vec[1];
   assign fire_pop  = fire_vec[2];
endmodule

// File: rtl/wp_checker.sv
module wp_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       acc_valid,
   input logic [1:0] acc_kind,
   input logic       eng_busy,
   input logic       latch_full,
   input logic       pause_n,
   input logic       xfer_active,
   input logic       fire_cmd,
   input logic       fire_push,
   input logic       fire_pop
);
   logic any_fire;
   logic live;
   assign any_fire = fire_cmd || fire_push || fire_pop;
   assign live     = acc_valid && (acc_kind != 2'd3);

   always_comb begin
      if (!rst_n) begin
         assert_reset_release_R1: assert (pause_n && !any_fire);
      end
   end

   assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (pause_n && !any_fire));

   assert_busy_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (live && eng_busy && !$past(pause_n)) |-> (!pause_n && !any_fire));

   assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (live && acc_kind == 2'd2 && latch_full && !$past(pause_n)) |-> (!pause_n && !xfer_active));

   assert_single_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
      any_fire |=> (!any_fire && (!acc_valid || pause_n)));

   assert_fire_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fire_cmd, fire_push, fire_pop}));

   assert_fire_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      any_fire |-> pause_n);

   assert_xfer_pop_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_active |-> (acc_valid && acc_kind == 2'd2 && !eng_busy && !pause_n));

   assert_none_kind_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_kind == 2'd3) |-> (pause_n && !any_fire));
endmodule

bind wait_pause_gen wp_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_valid   (acc_valid),
   .acc_kind    (acc_kind),
   .eng_busy    (eng_busy),
   .latch_full  (latch_full),
   .pause_n     (pause_n),
   .xfer_active (xfer_active),
   .fire_cmd    (fire_cmd),
   .fire_push   (fire_push),
   .fire_pop    (fire_pop)
);

// File: tb/wait_pause_gen_tb.sv
module wait_pause_gen_tb;
   localparam int DLY  = 4;
   localparam int XFER = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic [1:0] acc_kind = 2'd0;
   logic       eng_busy = 1'b0;
   logic       latch_full = 1'b0;
   logic       pause_n;
   logic       xfer_active;
   logic       fire_cmd, fire_push, fire_pop;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   wait_pause_gen #(.DLY_STAGES(DLY), .XFER_CYCLES(XFER)) u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
      .eng_busy(eng_busy), .latch_full(latch_full), .pause_n(pause_n),
      .xfer_active(xfer_active), .fire_cmd(fire_cmd), .fire_push(fire_push),
      .fire_pop(fire_pop)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int fires();
      return {29'd0, fire_pop, fire_push, fire_cmd};
   endfunction

   // One strobe; busy held for cycles < busy_until, latch full for cycles < latch_until.
   task automatic run_access(input logic [1:0] kind, input int busy_until,
                             input int latch_until, input int exp_low,
                             input int exp_xfer, input string req);
      int low = -1;
      int xf  = 0;
      bit stray = 1'b0;
      for (int c = 0; c < 60 && low < 0; c++) begin
         @(negedge clk);
         acc_valid  = 1'b1;
         acc_kind   = kind;
         eng_busy   = (c < busy_until);
         latch_full = (c < latch_until);
         #1;
         if (xfer_active) xf++;
         if (pause_n) begin
            low = c;
            check(fires() == (1 << kind), {req, " fire kind"}, fires(), 1 << kind);
         end else if (fires() != 0) begin
            stray = 1'b1;
         end
      end
      check(!stray, {req, " no fire while held"}, stray, 0);
      check(low == exp_low, {req, " low cycles"}, low, exp_low);
      check(xf == exp_xfer, {req, " xfer cycles"}, xf, exp_xfer);
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         #1;
         check(pause_n && fires() == 0, "R8 after fire", {31'd0, pause_n} + fires() * 2, 1);
      end
      @(negedge clk);
      acc_valid = 1'b0; eng_busy = 1'b0; latch_full = 1'b0;
      #1;
      check(pause_n && fires() == 0, "R2 released", fires(), 0);
      @(negedge clk);
   endtask

   task automatic t_reset();
      acc_valid = 1'b1; acc_kind = 2'd0; eng_busy = 1'b1;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk); #1;
         check(pause_n === 1'b1 && fires() == 0, "R1 reset state", pause_n, 1);
      end
      @(negedge clk);
      acc_valid = 1'b0; eng_busy = 1'b0;
      rst_n = 1'b1;
   endtask

   task automatic t_idle();
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         latch_full = c[0]; eng_busy = c[1];
         #1;
         check(pause_n && fires() == 0 && !xfer_active, "R2 idle bus", pause_n, 1);
      end
      @(negedge clk);
      latch_full = 1'b0; eng_busy = 1'b0;
   endtask

   task automatic t_none_kind();
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         acc_valid = 1'b1; acc_kind = 2'd3;
         #1;
         check(pause_n && fires() == 0, "R12 kind 3 ignored", fires(), 0);
      end
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic t_restart();
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         acc_valid = 1'b1; acc_kind = 2'd0;
         #1;
         check(!pause_n, "R11 partial strobe held", pause_n, 0);
      end
      @(negedge clk);
      acc_valid = 1'b0;
      #1;
      check(pause_n, "R11 gap releases", pause_n, 1);
      run_access(2'd0, 0, 0, DLY, 0, "R11 full delay again");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_idle();
      run_access(2'd0, 0, 0, DLY, 0, "R3 idle cmd write");
      run_access(2'd1, 0, 0, DLY, 0, "R3 idle push");
      run_access(2'd0, 9, 0, 9, 0, "R4 cmd write while busy");
      run_access(2'd1, 2, 0, DLY, 0, "R5 push short busy");
      run_access(2'd1, 7, 0, 7, 0, "R5 push while busy");
      run_access(2'd2, 0, 0, DLY + XFER, XFER, "R6 idle pop");
      run_access(2'd2, 8, 0, 8 + XFER, XFER, "R10 pop while busy");
      run_access(2'd2, 0, 9, 9 + XFER, XFER, "R7 pop latch full");
      run_access(2'd2, 6, 9, 9 + XFER, XFER, "R7 R10 busy and latch");
      t_none_kind();
      t_restart();
      finished = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule